// File: doc/BRIEF.md
# Confirmed-Write Power Mode Controller

This block holds the operating mode of a device: Reset, Normal or Deep Power-Down. Software changes the mode through a small register bus, and a change takes effect only after a two-step handshake. First a byte is written to the mode register. Then the bitwise complement of that byte is written to the confirm register. Any other order is dropped. This makes a stray single write harmless.

A pin-control register selects whether an external sleep pin is ignored, or forces Deep Power-Down while it is high or while it is low. Once in Deep Power-Down, the block leaves only through the active-low hardware reset, and it comes out in Reset mode.

An output-control register survives a Reset mode entered by software. It is cleared only by the hardware reset. The pin-control register, by contrast, is cleared by a software Reset entry.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After rst_ni is asserted, mode_o is 00 (Reset), the pin-control field is 0000, the output-control register is 0, and the sleep-status bit is 0.
- R2: Mode encoding is 00=Reset, 01=Normal, 10=Deep Power-Down, taken from bits [1:0] of the mode register value. The new mode appears on mode_o in the cycle after the confirm write (address 1) whose data equals the bitwise complement of the last mode-register write (address 0).
- R3: A confirm write whose data is not the exact complement of the pending value discards the pending change, and the mode stays unchanged.
- R4: A write to any address other than 0 or 1 between the two writes discards the pending change. A confirm write with nothing pending is ignored.
- R5: A confirmed value whose bits [1:0] are 11 is discarded. mode_o never shows 11.
- R6: A read at address 0 and a read at address 1 both return the current mode in bits [1:0], with all other bits 0.
- R7: The pin-control field sits at address 2, bits [3:0]. Code 0001 enters Deep Power-Down while the sleep pin is high. Code 0010 enters it while the pin is low. Every other code ignores the pin. Pin entry happens only from Normal mode, within SYNC_STAGES+1 cycles.
- R8: In Deep Power-Down, register writes never change the mode. Only rst_ni leaves it, and the block then returns to Reset mode.
- R9: Bit 7 of address 2 is a read-only sleep-status bit. It reads 1 while the mode is Deep Power-Down and 0 otherwise, and it is 0 after reset.
- R10: The output-control register (address 3) changes only on a write to address 3 or on rst_ni. A Reset entry through the handshake leaves it intact.
- R11: An accepted handshake into Reset mode clears the pin-control field to 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous hardware reset |
| we_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register address for write and read |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for addr_i (combinational) |
| sleep_pin_i | input | 1 | Asynchronous sleep request pin |
| mode_o | output | 2 | Current operating mode |
| out_ctrl_o | output | DATA_W | Output-control register contents |

## Verification
The bench walks the handshake with the following disturbances:
- a wrong complement;
- a write to an unrelated register between the two steps;
- a confirm write with nothing pending;
- the reserved code 11.

A design that committed on a bare mode-register write, or that kept the pending value alive across other writes, would move mode_o where the table expects it to stay put.

The bench also tries to leave Deep Power-Down by a valid handshake. A design that honoured that handshake would show Normal instead of Deep Power-Down.

It checks that the output-control value survives a software Reset while the pin-control field is wiped. Swapping these clear paths would corrupt one of the two read-backs.

Pin polarity and the ignore code are exercised, along with pin activity outside Normal mode. An inverted decode, or entry from Reset mode, would show up as a wrong mode.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [1:0] {
    MODE_RST   = 2'b00,
    MODE_RUN   = 2'b01,
    MODE_SLEEP = 2'b10
  } pmode_e;

  localparam int unsigned A_MODE = 0;
  localparam int unsigned A_CONF = 1;
  localparam int unsigned A_PIN  = 2;
  localparam int unsigned A_OUT  = 3;

  localparam logic [3:0] PIN_OFF  = 4'b0000;
  localparam logic [3:0] PIN_HIGH = 4'b0001;
  localparam logic [3:0] PIN_LOW  = 4'b0010;
endpackage

// File: rtl/pmc_seq.sv
module pmc_seq
  import pmc_pkg::*;
#(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              commit_o,
  output logic [1:0]        code_o
);
  logic              pend_q;
  logic [DATA_W-1:0] val_q;
  logic              is_mode, is_conf;

  assign is_mode = (addr_i == ADDR_W'(A_MODE));
  assign is_conf = (addr_i == ADDR_W'(A_CONF));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      val_q  <= '0;
    end else if (we_i) begin
      pend_q <= is_mode;  // any other write drops the pending value
      if (is_mode) val_q <= wdata_i;
    end
  end

  assign commit_o = we_i && is_conf && pend_q &&
                    (wdata_i == ~val_q) && (val_q[1:0] != 2'b11);
  assign code_o   = val_q[1:0];

  // R4
  drop_on_other_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !is_mode) |=> !pend_q);
  // R5
  no_bad_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> (code_o != 2'b11));
endmodule

// File: rtl/pmc_pin.sv
module pmc_pin
  import pmc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pin_i,
  input  logic [3:0] pin_mode_i,
  output logic       hit_o
);
  logic [SYNC_STAGES-1:0] sync_q;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[i] <= 1'b0;
        else if (i == 0) sync_q[i] <= pin_i;
        else sync_q[i] <= sync_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  always_comb begin
    unique case (pin_mode_i)
      PIN_HIGH: hit_o = sync_q[SYNC_STAGES-1];
      PIN_LOW:  hit_o = !sync_q[SYNC_STAGES-1];
      default:  hit_o = 1'b0;
    endcase
  end

  // R7
  off_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_mode_i != PIN_HIGH && pin_mode_i != PIN_LOW) |-> !hit_o);
endmodule

// File: rtl/pmc_fsm.sv
module pmc_fsm
  import pmc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       commit_i,
  input  logic [1:0] code_i,
  input  logic       pin_hit_i,
  output pmode_e     mode_o,
  output logic       pd_ok_o,
  output logic       rst_entry_o
);
  pmode_e mode_q, mode_d;
  logic   pd_ok_q, pin_take;

  assign pin_take = pin_hit_i && (mode_q == MODE_RUN);

  always_comb begin
    mode_d = mode_q;
    if (mode_q == MODE_SLEEP) mode_d = MODE_SLEEP;  // only rst_ni leaves
    else if (pin_take)        mode_d = MODE_SLEEP;
    else if (commit_i)        mode_d = pmode_e'(code_i);
  end

  assign rst_entry_o = commit_i && !pin_take && (mode_q != MODE_SLEEP) &&
                       (code_i == MODE_RST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_RST;
      pd_ok_q <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      pd_ok_q <= (mode_d == MODE_SLEEP);
    end
  end

  assign mode_o  = mode_q;
  assign pd_ok_o = pd_ok_q;

  // R2
  change_needs_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q != $past(mode_q) && mode_q != MODE_SLEEP) |-> $past(commit_i));
  // R8
  sleep_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_q) == MODE_SLEEP) |-> (mode_q == MODE_SLEEP));
  // R5
  legal_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q != 2'b11);
  // R9
  pd_ok_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_ok_q == (mode_q == MODE_SLEEP));
endmodule

// File: rtl/pmc_regs.sv
module pmc_regs
  import pmc_pkg::*;
#(
  parameter int unsigned ADDR_W = 2,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [1:0]        mode_i,
  input  logic              pd_ok_i,
  input  logic              rst_entry_i,
  output logic [3:0]        pin_mode_o,
  output logic [DATA_W-1:0] out_ctrl_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [3:0]        pin_q;
  logic [DATA_W-1:0] out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_q <= '0;
    else if (rst_entry_i) pin_q <= '0;
    else if (we_i && addr_i == ADDR_W'(A_PIN)) pin_q <= wdata_i[3:0];
  end

  // hardware reset only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_q <= '0;
    else if (we_i && addr_i == ADDR_W'(A_OUT)) out_q <= wdata_i;
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_W'(A_MODE) || addr_i == ADDR_W'(A_CONF)) begin
      rdata_o[1:0] = mode_i;
    end else if (addr_i == ADDR_W'(A_PIN)) begin
      rdata_o[3:0]        = pin_q;
      rdata_o[DATA_W-1]   = pd_ok_i;
    end else if (addr_i == ADDR_W'(A_OUT)) begin
      rdata_o = out_q;
    end
  end

  assign pin_mode_o = pin_q;
  assign out_ctrl_o = out_q;

  // R10
  out_write_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(out_q) |-> $past(we_i && addr_i == ADDR_W'(A_OUT)));
  // R11
  pin_soft_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_entry_i |=> (pin_q == 4'b0000));
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int unsigned ADDR_W      = 2,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              sleep_pin_i,
  output logic [1:0]        mode_o,
  output logic [DATA_W-1:0] out_ctrl_o
);
  logic       commit, pin_hit, pd_ok, rst_entry;
  logic [1:0] code;
  logic [3:0] pin_mode;
  pmode_e     mode;

  pmc_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
    .commit_o(commit), .code_o(code)
  );

  pmc_pin #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
    .clk_i, .rst_ni, .pin_i(sleep_pin_i), .pin_mode_i(pin_mode), .hit_o(pin_hit)
  );

  pmc_fsm u_fsm (
    .clk_i, .rst_ni, .commit_i(commit), .code_i(code), .pin_hit_i(pin_hit),
    .mode_o(mode), .pd_ok_o(pd_ok), .rst_entry_o(rst_entry)
  );

  pmc_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
    .mode_i(mode), .pd_ok_i(pd_ok), .rst_entry_i(rst_entry),
    .pin_mode_o(pin_mode), .out_ctrl_o, .rdata_o
  );

  assign mode_o = mode;
endmodule

// File: tb/sim_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module sim_pwr_mode_ctrl;
  logic       clk = 0, rst_n = 0, we = 0, pin = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0, rdata, outc;
  logic [1:0] mode;
  int total = 0, bad = 0;

  always #10 clk = ~clk;  // 50 MHz

  pwr_mode_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .sleep_pin_i(pin), .mode_o(mode), .out_ctrl_o(outc)
  );

  // {addr, data, expected mode after write}
  localparam int NV = 18;
  localparam logic [11:0] VEC [0:NV-1] = '{
    {2'd0, 8'h01, 2'b00},  // R2 first step only
    {2'd1, 8'hFE, 2'b01},  // R2 -> Normal
    {2'd0, 8'h00, 2'b01},
    {2'd1, 8'hFE, 2'b01},  // R3 wrong complement
    {2'd1, 8'hFF, 2'b01},  // R4 nothing pending
    {2'd0, 8'h00, 2'b01},
    {2'd3, 8'h5A, 2'b01},  // R4 intervening write
    {2'd1, 8'hFF, 2'b01},
    {2'd0, 8'h00, 2'b01},
    {2'd1, 8'hFF, 2'b00},  // R2 -> Reset
    {2'd0, 8'h03, 2'b00},
    {2'd1, 8'hFC, 2'b00},  // R5 code 11
    {2'd0, 8'h01, 2'b00},
    {2'd1, 8'hFE, 2'b01},
    {2'd0, 8'h02, 2'b01},
    {2'd1, 8'hFD, 2'b10},  // R2 -> Deep Power-Down
    {2'd0, 8'h01, 2'b10},
    {2'd1, 8'hFE, 2'b10}   // R8 handshake ignored in sleep
  };

  task automatic chk(input string req, input int got, input int exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic hw_reset();
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic go(input logic [1:0] m);
    wr(2'd0, {6'd0, m}); wr(2'd1, ~{6'd0, m});
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] r;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 mode", mode, 0);
    rd(2'd2, r); chk("R1 pin ctrl/status", r, 0);
    chk("R1 out ctrl", outc, 0);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][11:10], VEC[i][9:2]);
      chk($sformatf("R2-R5/R8 vec %0d", i), mode, VEC[i][1:0]);
    end
    // R6 / R9 in sleep
    rd(2'd0, r); chk("R6 mode reg", r, 8'h02);
    rd(2'd1, r); chk("R6 confirm reg", r, 8'h02);
    rd(2'd2, r); chk("R9 status in sleep", r, 8'h80);
    chk("R10 out kept over soft reset", outc, 8'h5A);

    // R8 exit via hardware reset
    hw_reset();
    chk("R8 reset leaves sleep", mode, 0);
    rd(2'd2, r); chk("R9 status after reset", r, 0);
    chk("R10 out cleared by rst_ni", outc, 0);

    // R7 active-high
    go(2'b01);
    wr(2'd2, 8'h01);
    pin = 1; repeat (4) @(negedge clk);
    chk("R7 active-high entry", mode, 2);
    pin = 0; hw_reset();

    // R7 active-low
    pin = 1; repeat (3) @(negedge clk);
    go(2'b01);
    wr(2'd2, 8'h02);
    repeat (3) @(negedge clk);
    chk("R7 low polarity idle high", mode, 1);
    pin = 0; repeat (4) @(negedge clk);
    chk("R7 active-low entry", mode, 2);
    hw_reset();

    // R7 ignore codes and non-Normal modes
    go(2'b01);
    wr(2'd2, 8'h00);
    pin = 1; repeat (4) @(negedge clk);
    pin = 0; repeat (4) @(negedge clk);
    chk("R7 code 0000 ignores pin", mode, 1);
    wr(2'd2, 8'h05);
    pin = 1; repeat (4) @(negedge clk);
    chk("R7 code 0101 ignores pin", mode, 1);
    pin = 0;

    // R11 / R10 soft reset behaviour
    wr(2'd3, 8'hC3);
    wr(2'd2, 8'h01);
    go(2'b00);
    chk("R11 mode reset", mode, 0);
    rd(2'd2, r); chk("R11 pin ctrl cleared", r, 0);
    chk("R10 out survives soft reset", outc, 8'hC3);
    rd(2'd3, r); chk("R10 out readback", r, 8'hC3);
    wr(2'd2, 8'h01);
    pin = 1; repeat (4) @(negedge clk);
    chk("R7 no entry from Reset", mode, 0);
    pin = 0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule